// File: doc/BRIEF.md
# Branch Prediction History Recovery Buffer

The block holds an ordered log of branch predictions that are still in flight, one record for each predicted control instruction, keyed by a sequence number. Fetch appends a record for each prediction. The record holds the PC, the predicted direction and an opaque predictor-history handle. It also holds a return-stack checkpoint (a saved stack index and target, plus a flag saying the stack was used) and return and indirect flags. The direction predictor, the target buffer, the indirect target table and the return stack all sit outside the block. The block reaches them only through registered one-cycle command outputs.

Commit retires records from the old end and emits training or retire-squashed notices. Squash discards records from the young end and emits return-stack restores. A mispredict resolution finds one record and emits several commands: a corrective update, a write to the target table or the indirect table, and a stack pop or restore. Only one thread is supported.

Top module: `branch_hist_buf`

## Requirements
- R1: After reset the buffer is empty, `full` and `busy` are 0, and no command output is valid.
- R2: An accepted insert appends a record at the young end. `full` is 1 exactly when DEPTH records are held. An insert is dropped when the buffer is full, when `busy` is 1, or when another pulse is accepted in the same cycle.
- R3: At most one request is accepted per cycle, in this priority: squash, mispredict, commit, insert. While `busy` is 1, every request is ignored.
- R4: A commit with number N keeps `busy` high from the next cycle. In each cycle it retires the oldest record if that record's number is less than or equal to N (unsigned compare). The first cycle with no such record ends the operation and clears `busy`.
- R5: Retiring a record that is not marked squashed pulses `upd_valid` with the record's PC, predicted direction and history handle, and with `upd_squash`=0.
- R6: Retiring a record marked squashed pulses `rsq_valid` with its history handle, and pulses no update.
- R7: A squash with number S removes one record per cycle from the young end while that record's number is greater than S, holding `busy`. Each removed record with the stack-used flag set pulses `stk_rst_valid` with its saved index and target.
- R8: A mispredict for number S that matches a held record pulses `upd_valid` in the next cycle, with the actual outcome, the stored PC and handle, and `upd_squash`=1. The record is then marked squashed. A number that matches no record produces no output.
- R9: A mispredict with actual outcome taken, on a return record whose stack-used flag is clear, pulses `stk_pop` and sets that flag.
- R10: A mispredict with actual outcome taken writes the correct target. It goes to the indirect table (`ind_wr_*`, with sequence number and handle) when the record is indirect, and otherwise to the target buffer (`btb_wr_*`, with the PC).
- R11: A mispredict with actual outcome not taken, on a record whose stack-used flag is set, pulses `stk_rst_valid` with the saved index and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of new record |
| ins_pc | input | PC_W | Branch PC |
| ins_taken | input | 1 | Predicted direction |
| ins_hist | input | HIST_W | Opaque predictor history handle |
| ins_used | input | 1 | Return stack was used by this prediction |
| ins_sidx | input | SIDX_W | Saved stack index |
| ins_stgt | input | PC_W | Saved stack target |
| ins_ret | input | 1 | Record is a return |
| ins_ind | input | 1 | Record is an indirect branch |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Commit bound |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash bound |
| mp_valid | input | 1 | Mispredict resolution request |
| mp_seq | input | SEQ_W | Mispredicted record number |
| mp_taken | input | 1 | Actual outcome |
| mp_target | input | PC_W | Correct target |
| full | output | 1 | DEPTH records held |
| busy | output | 1 | Commit or squash in progress |
| upd_valid | output | 1 | Predictor update command |
| upd_pc | output | PC_W | Update PC |
| upd_taken | output | 1 | Update direction |
| upd_hist | output | HIST_W | Update history handle |
| upd_squash | output | 1 | Update comes from a mispredict |
| rsq_valid | output | 1 | Retire-squashed notice |
| rsq_hist | output | HIST_W | Handle of retired squashed record |
| btb_wr_valid | output | 1 | Target buffer write |
| btb_wr_pc | output | PC_W | Write PC |
| btb_wr_tgt | output | PC_W | Write target |
| ind_wr_valid | output | 1 | Indirect table write |
| ind_wr_seq | output | SEQ_W | Record number |
| ind_wr_hist | output | HIST_W | Record history handle |
| ind_wr_tgt | output | PC_W | Correct target |
| stk_rst_valid | output | 1 | Return stack restore |
| stk_rst_idx | output | SIDX_W | Restored index |
| stk_rst_tgt | output | PC_W | Restored target |
| stk_pop | output | 1 | Return stack pop |

## Verification
The hardest situation to reach is a record that carries the squashed mark and the stack-used flag, set by earlier mispredicts, which a later commit or squash then reaches. A return can gain the used flag only through a taken mispredict. Retire-squashed notices and restores that follow a pop need exactly that order of requests. The stimulus first builds a short log with directed flag combinations. It then mispredicts chosen numbers, squashes part of the log and commits the rest. After that, a long random phase keeps sequence numbers rising and picks mispredict numbers from records the bench model still holds, so the hit paths keep being taken.

// File: rtl/branch_hist_buf.sv
module branch_hist_buf #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int SIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic              ins_taken,
  input  logic [HIST_W-1:0] ins_hist,
  input  logic              ins_used,
  input  logic [SIDX_W-1:0] ins_sidx,
  input  logic [PC_W-1:0]   ins_stgt,
  input  logic              ins_ret,
  input  logic              ins_ind,
  input  logic              cmt_valid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sq_valid,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic              mp_valid,
  input  logic [SEQ_W-1:0]  mp_seq,
  input  logic              mp_taken,
  input  logic [PC_W-1:0]   mp_target,
  output logic              full,
  output logic              busy,
  output logic              upd_valid,
  output logic [PC_W-1:0]   upd_pc,
  output logic              upd_taken,
  output logic [HIST_W-1:0] upd_hist,
  output logic              upd_squash,
  output logic              rsq_valid,
  output logic [HIST_W-1:0] rsq_hist,
  output logic              btb_wr_valid,
  output logic [PC_W-1:0]   btb_wr_pc,
  output logic [PC_W-1:0]   btb_wr_tgt,
  output logic              ind_wr_valid,
  output logic [SEQ_W-1:0]  ind_wr_seq,
  output logic [HIST_W-1:0] ind_wr_hist,
  output logic [PC_W-1:0]   ind_wr_tgt,
  output logic              stk_rst_valid,
  output logic [SIDX_W-1:0] stk_rst_idx,
  output logic [PC_W-1:0]   stk_rst_tgt,
  output logic              stk_pop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = CNT_W + 1;

  typedef enum logic [1:0] {M_IDLE, M_CMT, M_SQ} mode_t;

  logic [SEQ_W-1:0]  r_seq  [DEPTH];
  logic [PC_W-1:0]   r_pc   [DEPTH];
  logic [HIST_W-1:0] r_hist [DEPTH];
  logic [SIDX_W-1:0] r_sidx [DEPTH];
  logic [PC_W-1:0]   r_stgt [DEPTH];
  logic              r_tk   [DEPTH];
  logic              r_used [DEPTH];
  logic              r_ret  [DEPTH];
  logic              r_ind  [DEPTH];
  logic              r_sqd  [DEPTH];

  mode_t             mode;
  logic [SEQ_W-1:0]  pend;
  logic [PTR_W-1:0]  head, tail, yng;
  logic [CNT_W-1:0]  count;
  logic [SUM_W-1:0]  tsum;
  logic              idle, sq_go, mp_go, cm_go, in_go;
  logic              mp_hit;
  logic [PTR_W-1:0]  mp_at;

  assign full  = (count == CNT_W'(DEPTH));
  assign idle  = (mode == M_IDLE);
  assign busy  = !idle;
  assign sq_go = idle && sq_valid;
  assign mp_go = idle && !sq_valid && mp_valid;
  assign cm_go = idle && !sq_valid && !mp_valid && cmt_valid;
  assign in_go = idle && !sq_valid && !mp_valid && !cmt_valid && ins_valid && !full;

  assign tsum = SUM_W'(head) + SUM_W'(count);
  assign tail = PTR_W'((tsum >= SUM_W'(DEPTH)) ? tsum - SUM_W'(DEPTH) : tsum);
  assign yng  = (tail == '0) ? PTR_W'(DEPTH - 1) : tail - 1'b1;

  always_comb begin
    logic [SUM_W-1:0] s;
    mp_hit = 1'b0;
    mp_at  = '0;
    s      = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      s = SUM_W'(head) + SUM_W'(i);
      if (s >= SUM_W'(DEPTH)) s = s - SUM_W'(DEPTH);
      if (SUM_W'(i) < SUM_W'(count) && r_seq[PTR_W'(s)] == mp_seq) begin
        mp_hit = 1'b1;
        mp_at  = PTR_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IDLE; pend <= '0; head <= '0; count <= '0;
      upd_valid <= 1'b0; rsq_valid <= 1'b0; btb_wr_valid <= 1'b0;
      ind_wr_valid <= 1'b0; stk_rst_valid <= 1'b0; stk_pop <= 1'b0;
      upd_pc <= '0; upd_taken <= 1'b0; upd_hist <= '0; upd_squash <= 1'b0;
      rsq_hist <= '0; btb_wr_pc <= '0; btb_wr_tgt <= '0;
      ind_wr_seq <= '0; ind_wr_hist <= '0; ind_wr_tgt <= '0;
      stk_rst_idx <= '0; stk_rst_tgt <= '0;
    end else begin
      upd_valid <= 1'b0; rsq_valid <= 1'b0; btb_wr_valid <= 1'b0;
      ind_wr_valid <= 1'b0; stk_rst_valid <= 1'b0; stk_pop <= 1'b0;
      case (mode)
        M_CMT: begin
          if (count != '0 && r_seq[head] <= pend) begin
            if (r_sqd[head]) begin
              rsq_valid <= 1'b1; rsq_hist <= r_hist[head];
            end else begin
              upd_valid <= 1'b1; upd_pc <= r_pc[head]; upd_taken <= r_tk[head];
              upd_hist <= r_hist[head]; upd_squash <= 1'b0;
            end
            head  <= (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
            count <= count - 1'b1;
          end else mode <= M_IDLE;
        end
        M_SQ: begin
          if (count != '0 && r_seq[yng] > pend) begin
            if (r_used[yng]) begin
              stk_rst_valid <= 1'b1; stk_rst_idx <= r_sidx[yng]; stk_rst_tgt <= r_stgt[yng];
            end
            count <= count - 1'b1;
          end else mode <= M_IDLE;
        end
        default: begin
          if (sq_go) begin
            mode <= M_SQ; pend <= sq_seq;
          end else if (mp_go) begin
            if (mp_hit) begin
              upd_valid <= 1'b1; upd_pc <= r_pc[mp_at]; upd_taken <= mp_taken;
              upd_hist <= r_hist[mp_at]; upd_squash <= 1'b1;
              r_sqd[mp_at] <= 1'b1;
              if (mp_taken) begin
                if (r_ret[mp_at] && !r_used[mp_at]) begin
                  stk_pop <= 1'b1; r_used[mp_at] <= 1'b1;
                end
                if (r_ind[mp_at]) begin
                  ind_wr_valid <= 1'b1; ind_wr_seq <= r_seq[mp_at];
                  ind_wr_hist <= r_hist[mp_at]; ind_wr_tgt <= mp_target;
                end else begin
                  btb_wr_valid <= 1'b1; btb_wr_pc <= r_pc[mp_at]; btb_wr_tgt <= mp_target;
                end
              end else if (r_used[mp_at]) begin
                stk_rst_valid <= 1'b1; stk_rst_idx <= r_sidx[mp_at]; stk_rst_tgt <= r_stgt[mp_at];
              end
            end
          end else if (cm_go) begin
            mode <= M_CMT; pend <= cmt_seq;
          end else if (in_go) begin
            r_seq[tail] <= ins_seq; r_pc[tail] <= ins_pc; r_tk[tail] <= ins_taken;
            r_hist[tail] <= ins_hist; r_used[tail] <= ins_used; r_sidx[tail] <= ins_sidx;
            r_stgt[tail] <= ins_stgt; r_ret[tail] <= ins_ret; r_ind[tail] <= ins_ind;
            r_sqd[tail] <= 1'b0;
            count <= count + 1'b1;
          end
        end
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R2
  full_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> count <= $past(count));
  // R9
  pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_pop |-> $past(mp_go) && $past(mp_taken));
  // R10
  one_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(btb_wr_valid && ind_wr_valid));
  // R5
  retire_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_squash) |-> $past(mode == M_CMT));
  // R7
  restore_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_rst_valid |-> ($past(mode == M_SQ) || ($past(mp_go) && !$past(mp_taken))));
  // R3
  one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sq_go, mp_go, cm_go, in_go}) <= 1);
endmodule

// File: tb/test_branch_hist_buf.sv
module test_branch_hist_buf;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = !clk;

  logic ins_valid, ins_taken, ins_used, ins_ret, ins_ind;
  logic [15:0] ins_seq, cmt_seq, sq_seq, mp_seq;
  logic [31:0] ins_pc, ins_stgt, mp_target;
  logic [7:0]  ins_hist;
  logic [3:0]  ins_sidx;
  logic cmt_valid, sq_valid, mp_valid, mp_taken;
  logic full, busy, upd_valid, upd_taken, upd_squash, rsq_valid;
  logic btb_wr_valid, ind_wr_valid, stk_rst_valid, stk_pop;
  logic [31:0] upd_pc, btb_wr_pc, btb_wr_tgt, ind_wr_tgt, stk_rst_tgt;
  logic [7:0]  upd_hist, rsq_hist, ind_wr_hist;
  logic [15:0] ind_wr_seq;
  logic [3:0]  stk_rst_idx;

  branch_hist_buf i_branch_hist_buf (.*);

  typedef struct {
    int unsigned seq, pc, hist, idx, tgt;
    bit tk, used, ret, ind, sqd;
  } rec_t;
  rec_t q[$];
  int mm = 0;
  int unsigned mpend = 0;
  bit e_upd, e_utk, e_usq, e_rsq, e_btb, e_ind, e_rst, e_pop;
  int unsigned e_upc, e_uh, e_rh, e_bpc, e_btg, e_iseq, e_ih, e_itg, e_ridx, e_rtg;
  int nchk = 0, nerr = 0;

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clr();
    ins_valid = 0; ins_seq = 0; ins_pc = 0; ins_taken = 0; ins_hist = 0; ins_used = 0;
    ins_sidx = 0; ins_stgt = 0; ins_ret = 0; ins_ind = 0;
    cmt_valid = 0; cmt_seq = 0; sq_valid = 0; sq_seq = 0;
    mp_valid = 0; mp_seq = 0; mp_taken = 0; mp_target = 0;
  endtask

  task automatic step();
    rec_t r;
    int at;
    {e_upd, e_rsq, e_btb, e_ind, e_rst, e_pop} = '0;
    if (mm == 1) begin
      if (q.size() > 0 && q[0].seq <= mpend) begin
        r = q.pop_front();
        if (r.sqd) begin e_rsq = 1; e_rh = r.hist; end
        else begin e_upd = 1; e_upc = r.pc; e_utk = r.tk; e_uh = r.hist; e_usq = 0; end
      end else mm = 0;
    end else if (mm == 2) begin
      if (q.size() > 0 && q[$].seq > mpend) begin
        r = q.pop_back();
        if (r.used) begin e_rst = 1; e_ridx = r.idx; e_rtg = r.tgt; end
      end else mm = 0;
    end else if (sq_valid) begin
      mm = 2; mpend = sq_seq;
    end else if (mp_valid) begin
      at = -1;
      foreach (q[i]) if (at < 0 && q[i].seq == mp_seq) at = i;
      if (at >= 0) begin
        r = q[at];
        e_upd = 1; e_upc = r.pc; e_utk = mp_taken; e_uh = r.hist; e_usq = 1;
        r.sqd = 1;
        if (mp_taken) begin
          if (r.ret && !r.used) begin e_pop = 1; r.used = 1; end
          if (r.ind) begin e_ind = 1; e_iseq = r.seq; e_ih = r.hist; e_itg = mp_target; end
          else begin e_btb = 1; e_bpc = r.pc; e_btg = mp_target; end
        end else if (r.used) begin
          e_rst = 1; e_ridx = r.idx; e_rtg = r.tgt;
        end
        q[at] = r;
      end
    end else if (cmt_valid) begin
      mm = 1; mpend = cmt_seq;
    end else if (ins_valid && q.size() < D) begin
      r.seq = ins_seq; r.pc = ins_pc; r.tk = ins_taken; r.hist = ins_hist; r.used = ins_used;
      r.idx = ins_sidx; r.tgt = ins_stgt; r.ret = ins_ret; r.ind = ins_ind; r.sqd = 0;
      q.push_back(r);
    end
  endtask

  task automatic compare();
    chk("R2", "full", full, q.size() == D);
    chk("R4/R7", "busy", busy, mm != 0);
    chk("R5/R8", "upd_valid", upd_valid, e_upd);
    if (e_upd) begin
      chk("R5/R8", "upd_pc", upd_pc, e_upc);
      chk("R5/R8", "upd_taken", upd_taken, e_utk);
      chk("R5/R8", "upd_hist", upd_hist, e_uh);
      chk("R5/R8", "upd_squash", upd_squash, e_usq);
    end
    chk("R6", "rsq_valid", rsq_valid, e_rsq);
    if (e_rsq) chk("R6", "rsq_hist", rsq_hist, e_rh);
    chk("R10", "btb_wr_valid", btb_wr_valid, e_btb);
    if (e_btb) begin
      chk("R10", "btb_wr_pc", btb_wr_pc, e_bpc);
      chk("R10", "btb_wr_tgt", btb_wr_tgt, e_btg);
    end
    chk("R10", "ind_wr_valid", ind_wr_valid, e_ind);
    if (e_ind) begin
      chk("R10", "ind_wr_seq", ind_wr_seq, e_iseq);
      chk("R10", "ind_wr_hist", ind_wr_hist, e_ih);
      chk("R10", "ind_wr_tgt", ind_wr_tgt, e_itg);
    end
    chk("R7/R11", "stk_rst_valid", stk_rst_valid, e_rst);
    if (e_rst) begin
      chk("R7/R11", "stk_rst_idx", stk_rst_idx, e_ridx);
      chk("R7/R11", "stk_rst_tgt", stk_rst_tgt, e_rtg);
    end
    chk("R9", "stk_pop", stk_pop, e_pop);
  endtask

  task automatic tick();
    step();
    @(posedge clk);
    @(negedge clk);
    compare();
    clr();
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && mm != 0; k++) tick();
  endtask

  task automatic put(int unsigned s, bit used, bit ret, bit ind);
    ins_valid = 1; ins_seq = 16'(s); ins_pc = 32'h1000 + s * 4; ins_taken = s[0];
    ins_hist = 8'(s * 7); ins_used = used; ins_sidx = 4'(s); ins_stgt = 32'h8000 + s;
    ins_ret = ret; ins_ind = ind;
  endtask

  task automatic mpr(int unsigned s, bit tk, int unsigned tgt);
    mp_valid = 1; mp_seq = 16'(s); mp_taken = tk; mp_target = tgt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int unsigned nseq;
    int r;
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "full", full, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "cmd valids", {upd_valid, rsq_valid, btb_wr_valid, ind_wr_valid, stk_rst_valid, stk_pop}, 0);
    rst_n = 1;
    tick();
    chk("R1", "cmd valids after release", {upd_valid, rsq_valid, stk_pop}, 0);

    put(10, 0, 0, 0); tick();
    put(20, 0, 1, 0); tick();
    put(30, 0, 0, 1); tick();
    put(40, 1, 0, 0); tick();
    put(50, 1, 1, 0); tick();
    mpr(30, 1, 32'h3333); tick();     // R10 indirect
    mpr(20, 1, 32'h2222); tick();     // R9 pop + target buffer
    mpr(40, 0, 0); tick();            // R11 restore
    mpr(99, 1, 32'h9); tick();        // R8 no match
    mpr(20, 0, 0); tick();            // R11 used set by the earlier pop
    sq_valid = 1; sq_seq = 30; put(60, 0, 0, 0); tick();
    // R3 squash wins over insert, busy follows
    chk("R3", "busy after squash", busy, 1);
    drain();
    cmt_valid = 1; cmt_seq = 25; mp_valid = 1; mp_seq = 10; tick();  // R3 mispredict before commit
    cmt_valid = 1; cmt_seq = 25; put(70, 0, 0, 0); tick();
    mpr(30, 0, 0); put(80, 0, 0, 0); tick();    // R3 ignored while busy
    drain();
    for (int k = 0; k < D + 2; k++) begin put(100 + k, k[1], k[2], k[0]); tick(); end
    chk("R2", "full after fill", full, 1);
    cmt_valid = 1; cmt_seq = 16'hffff; tick();
    drain();
    chk("R4", "busy after full drain", busy, 0);

    nseq = 200;
    for (int c = 0; c < 4000; c++) begin
      r = int'($urandom % 100);
      if (r < 45) begin put(nseq, 1'($urandom), 1'($urandom), 1'($urandom)); nseq += 1 + $urandom % 3; end
      else if (r < 55) begin cmt_valid = 1; cmt_seq = 16'(nseq - $urandom % 24); end
      else if (r < 61) begin sq_valid = 1; sq_seq = 16'(nseq - $urandom % 14); end
      else if (r < 80 && q.size() > 0) mpr(q[$urandom % q.size()].seq, 1'($urandom), $urandom);
      if ($urandom % 10 == 0) begin cmt_valid = 1; cmt_seq = 16'(nseq - 30); end
      if ($urandom % 20 == 0) begin mp_valid = 1; mp_seq = 16'(nseq); mp_taken = 1; end
      tick();
    end
    cmt_valid = 1; cmt_seq = 16'hffff; tick();
    drain();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule